// File: doc/BRIEF.md
# DRAM ECC Error Logging Registers

This block keeps a small set of registers that record memory error events so that software can poll them. Single-bit (correctable) and multi-bit (uncorrectable) ECC events arrive as one-cycle pulses. Each pulse carries a 33-bit failing address, a channel bit and an 8-bit syndrome. Refresh-timeout, lock-to-non-DRAM and thermal events arrive as plain pulses.

Software reads and writes the registers through a simple select/write-enable port with combinational read data. The status bits are cleared by writing ones to them. A command register picks which status bits raise the system-error output.

The logged address, channel and syndrome follow a priority rule. Uncorrectable details replace correctable ones. Details that are already held are never replaced by an error of the same or lower severity.

Top module: `dram_err_log`

## Requirements
- R1: After reset, every register reads zero and `serr_o` is low.
- R2: A pulse sets its status bit one clock later: bit 0 for correctable ECC, bit 1 for uncorrectable ECC, bit 8 for refresh timeout, bit 9 for lock to non-DRAM memory, bit 11 for thermal. All other status bits read zero, so the status is always within mask 0x0B03.
- R3: A write to the status register (select 0) clears each bit whose data bit is 1. Bits written with 0 keep their value.
- R4: A correctable event arriving while neither ECC status bit is set logs its details. The pointer (select 2) reads {addr[31:7], 6'b0, channel}. The extended pointer (select 3) reads addr[32] in bit 0 with zeros above. The syndrome register (select 4) reads the syndrome in bits 7:0.
- R5: An uncorrectable event arriving while status bit 1 is clear logs its own details, replacing any correctable details. When both events arrive in the same cycle, the uncorrectable details are logged.
- R6: While status bit 1 is set, no ECC event changes the logged details. While only bit 0 is set, a further correctable event does not change them.
- R7: The command register (select 1) stores write data bits 0, 1, 8, 9 and 11. Its other bits read zero.
- R8: `serr_o` is high exactly while some status bit and the command bit at the same position are both set.
- R9: When a clearing write and a new event hit the same status bit in the same cycle, the bit stays set.
- R10: Writes to selects 2, 3 and 4 leave the logged details unchanged.
- R11: Selects 5 to 7 read zero. Read data of narrower registers is zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_evt_i | input | 1 | Correctable ECC event pulse |
| ue_evt_i | input | 1 | Uncorrectable ECC event pulse |
| evt_addr_i | input | 33 | Failing address of the ECC event |
| evt_chan_i | input | 1 | Channel of the ECC event |
| evt_syn_i | input | 8 | ECC syndrome of the event |
| rto_evt_i | input | 1 | Refresh-timeout event pulse |
| lck_evt_i | input | 1 | Lock-to-non-DRAM event pulse |
| thm_evt_i | input | 1 | Thermal event pulse |
| reg_sel_i | input | 3 | Register select |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| serr_o | output | 1 | System-error output |

## Verification
The assertions assume that the address, channel and syndrome inputs are valid in the cycle of an ECC pulse. They also assume that writes are single-cycle, one register per cycle.

The bench raises every input on the falling edge and holds it for exactly one rising edge. Each pulse therefore lasts one cycle, and a write never overlaps a second write. Events and clearing writes are made to coincide only in the scenario that targets that collision.

// File: rtl/dram_err_pkg.sv
`timescale 1ns/1ps
package dram_err_pkg;
  localparam int ADDR_W   = 33;
  localparam int SYN_W    = 8;
  localparam int STAT_W   = 16;
  localparam int DATA_W   = 32;
  localparam int SEL_W    = 3;
  localparam int LINE_LSB = 7;
  localparam int LINE_W   = ADDR_W - LINE_LSB;
  localparam logic [STAT_W-1:0] ERR_MASK = 16'h0B03;
  localparam int B_CE  = 0;
  localparam int B_UE  = 1;
  localparam int B_RTO = 8;
  localparam int B_LCK = 9;
  localparam int B_THM = 11;

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_PTR  = 3'd2,
    SEL_XPTR = 3'd3,
    SEL_SYN  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/dram_err_status.sv
`timescale 1ns/1ps
module dram_err_status
  import dram_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_vec,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_data,
  input  logic              cmd_we,
  input  logic [STAT_W-1:0] cmd_data,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] cmd_q,
  output logic              serr_o
);
  logic [STAT_W-1:0] status_d;
  logic [STAT_W-1:0] clr_mask;
  logic              status_en;

  // Next state: clear requested ones, then let new events win.
  always_comb begin
    clr_mask  = clr_we ? clr_data : '0;
    status_d  = ((status_q & ~clr_mask) | evt_vec) & ERR_MASK;
    status_en = clr_we | (|evt_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_we) begin
      cmd_q <= cmd_data & ERR_MASK;
    end
  end

  assign serr_o = |(status_q & cmd_q);

  p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~ERR_MASK) == '0);
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we && clr_data[B_CE] && !evt_vec[B_CE] |=> !status_q[B_CE]);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we && (evt_vec == '0) |=> $stable(status_q));
  p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vec[B_CE] |=> status_q[B_CE]);
  p_serr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[B_THM] && cmd_q[B_THM] |-> serr_o);
  p_cmd_resv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q & ~ERR_MASK) == '0);
endmodule

// File: rtl/dram_err_capture.sv
`timescale 1ns/1ps
module dram_err_capture
  import dram_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic              ce_held,
  input  logic              ue_held,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chan,
  input  logic [SYN_W-1:0]  syn,
  output logic [DATA_W-1:0] ptr_o,
  output logic              xbit_o,
  output logic [SYN_W-1:0]  syn_q
);
  logic [LINE_W-1:0] line_q;
  logic              chan_q;
  logic              take_ue;
  logic              take_ce;
  logic              take;

  // Uncorrectable replaces correctable; nothing replaces held UE details.
  always_comb begin
    take_ue = ue_evt && !ue_held;
    take_ce = ce_evt && !ce_held && !ue_held && !ue_evt;
    take    = take_ue | take_ce;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      chan_q <= 1'b0;
      syn_q  <= '0;
    end else if (take) begin
      line_q <= addr[ADDR_W-1:LINE_LSB];
      chan_q <= chan;
      syn_q  <= syn;
    end
  end

  assign ptr_o  = {line_q[LINE_W-2:0], {(LINE_LSB-1){1'b0}}, chan_q};
  assign xbit_o = line_q[LINE_W-1];

  p_ue_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt && !ue_held |=> syn_q == $past(syn));
  p_ue_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ue_held |=> $stable(syn_q) && $stable(ptr_o));
  p_ce_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ce_held && !ue_evt |=> $stable(ptr_o));
  p_ptr_resv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_o[LINE_LSB-1:1] == '0);
endmodule

// File: rtl/dram_err_log.sv
`timescale 1ns/1ps
module dram_err_log
  import dram_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt_i,
  input  logic              ue_evt_i,
  input  logic [32:0]       evt_addr_i,
  input  logic              evt_chan_i,
  input  logic [7:0]        evt_syn_i,
  input  logic              rto_evt_i,
  input  logic              lck_evt_i,
  input  logic              thm_evt_i,
  input  logic [2:0]        reg_sel_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              serr_o
);
  logic [STAT_W-1:0] evt_vec;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] cmd_q;
  logic [DATA_W-1:0] ptr;
  logic              xbit;
  logic [SYN_W-1:0]  syn_q;
  logic              clr_we;
  logic              cmd_we;
  logic              unused_bits;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(reg_sel_i);

  always_comb begin
    evt_vec        = '0;
    evt_vec[B_CE]  = ce_evt_i;
    evt_vec[B_UE]  = ue_evt_i;
    evt_vec[B_RTO] = rto_evt_i;
    evt_vec[B_LCK] = lck_evt_i;
    evt_vec[B_THM] = thm_evt_i;
  end

  assign clr_we      = reg_we_i && (sel == SEL_STAT);
  assign cmd_we      = reg_we_i && (sel == SEL_CMD);
  assign unused_bits = ^{reg_wdata_i[DATA_W-1:STAT_W], evt_addr_i[LINE_LSB-1:0]};

  dram_err_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_vec  (evt_vec),
    .clr_we   (clr_we),
    .clr_data (reg_wdata_i[STAT_W-1:0]),
    .cmd_we   (cmd_we),
    .cmd_data (reg_wdata_i[STAT_W-1:0]),
    .status_q (status_q),
    .cmd_q    (cmd_q),
    .serr_o   (serr_o)
  );

  dram_err_capture u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_evt  (ce_evt_i),
    .ue_evt  (ue_evt_i),
    .ce_held (status_q[B_CE]),
    .ue_held (status_q[B_UE]),
    .addr    (evt_addr_i),
    .chan    (evt_chan_i),
    .syn     (evt_syn_i),
    .ptr_o   (ptr),
    .xbit_o  (xbit),
    .syn_q   (syn_q)
  );

  always_comb begin
    case (sel)
      SEL_STAT: reg_rdata_o = {{(DATA_W-STAT_W){1'b0}}, status_q};
      SEL_CMD:  reg_rdata_o = {{(DATA_W-STAT_W){1'b0}}, cmd_q};
      SEL_PTR:  reg_rdata_o = ptr;
      SEL_XPTR: reg_rdata_o = {{(DATA_W-1){1'b0}}, xbit};
      SEL_SYN:  reg_rdata_o = {{(DATA_W-SYN_W){1'b0}}, syn_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  p_serr_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !serr_o);
  p_ro_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_i && (sel == SEL_PTR) && !ce_evt_i && !ue_evt_i |=> $stable(ptr));
endmodule

// File: tb/dram_err_log_tb_top.sv
`timescale 1ns/1ps
module dram_err_log_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_evt_i = 1'b0, ue_evt_i = 1'b0;
  logic [32:0] evt_addr_i = '0;
  logic        evt_chan_i = 1'b0;
  logic [7:0]  evt_syn_i = '0;
  logic        rto_evt_i = 1'b0, lck_evt_i = 1'b0, thm_evt_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        serr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_err_log dut_i (
    .clk(clk), .rst_n(rst_n),
    .ce_evt_i(ce_evt_i), .ue_evt_i(ue_evt_i),
    .evt_addr_i(evt_addr_i), .evt_chan_i(evt_chan_i), .evt_syn_i(evt_syn_i),
    .rto_evt_i(rto_evt_i), .lck_evt_i(lck_evt_i), .thm_evt_i(thm_evt_i),
    .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .serr_o(serr_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    reg_sel_i = s;
    #0.5;
    v = reg_rdata_o;
  endtask

  // One cycle of stimulus: optional write plus event pulses.
  task automatic step(input bit we, input logic [2:0] s, input logic [31:0] wd,
                      input bit ce, input bit ue, input logic [32:0] a,
                      input bit ch, input logic [7:0] sy, input logic [2:0] misc);
    @(negedge clk);
    reg_we_i = we; reg_sel_i = s; reg_wdata_i = wd;
    ce_evt_i = ce; ue_evt_i = ue; evt_addr_i = a; evt_chan_i = ch; evt_syn_i = sy;
    {thm_evt_i, lck_evt_i, rto_evt_i} = misc;
    @(negedge clk);
    reg_we_i = 1'b0; ce_evt_i = 1'b0; ue_evt_i = 1'b0;
    {thm_evt_i, lck_evt_i, rto_evt_i} = 3'b000;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] wd);
    step(1'b1, s, wd, 1'b0, 1'b0, '0, 1'b0, '0, 3'b000);
  endtask

  task automatic ecc(input bit ce, input bit ue, input logic [32:0] a,
                     input bit ch, input logic [7:0] sy);
    step(1'b0, 3'd0, '0, ce, ue, a, ch, sy, 3'b000);
  endtask

  task automatic expect_log(input string req, input logic [31:0] p,
                            input logic [31:0] x, input logic [31:0] s);
    logic [31:0] v;
    rd(3'd2, v); chk(req, v, p);
    rd(3'd3, v); chk(req, v, x);
    rd(3'd4, v); chk(req, v, s);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), v); chk("R1 reset value", v, 32'h0);
    end
    chk("R1 serr after reset", {31'b0, serr_o}, 32'h0);
  endtask

  task automatic t_ce_log;
    logic [31:0] v;
    ecc(1'b1, 1'b0, 33'h1_2345_6789, 1'b1, 8'h5A);
    rd(3'd0, v); chk("R2 CE status bit0", v, 32'h0001);
    expect_log("R4 CE details", 32'h2345_6781, 32'h1, 32'h5A);
    ecc(1'b1, 1'b0, 33'h0_7777_7700, 1'b0, 8'h11);
    expect_log("R6 second CE ignored", 32'h2345_6781, 32'h1, 32'h5A);
  endtask

  task automatic t_ue_over;
    logic [31:0] v;
    ecc(1'b0, 1'b1, 33'h0_0ABC_DE80, 1'b0, 8'hC3);
    rd(3'd0, v); chk("R2 UE status bit1", v, 32'h0003);
    expect_log("R5 UE replaces CE", 32'h0ABC_DE80, 32'h0, 32'hC3);
    ecc(1'b1, 1'b0, 33'h1_FFFF_FF80, 1'b1, 8'h01);
    expect_log("R6 CE under UE ignored", 32'h0ABC_DE80, 32'h0, 32'hC3);
    ecc(1'b0, 1'b1, 33'h1_1111_1180, 1'b1, 8'h02);
    expect_log("R6 UE under UE ignored", 32'h0ABC_DE80, 32'h0, 32'hC3);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(3'd0, 32'h0000_0001);
    rd(3'd0, v); chk("R3 clear bit0 only", v, 32'h0002);
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, v); chk("R3 zero write keeps", v, 32'h0002);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R3 clear all", v, 32'h0000);
  endtask

  task automatic t_both;
    logic [31:0] v;
    ecc(1'b1, 1'b1, 33'h1_0000_1F80, 1'b1, 8'h3C);
    rd(3'd0, v); chk("R5 both status", v, 32'h0003);
    expect_log("R5 same cycle UE wins", 32'h0000_1F81, 32'h1, 32'h3C);
    wr(3'd0, 32'h0000_FFFF);
  endtask

  task automatic t_misc;
    logic [31:0] v;
    step(1'b0, 3'd0, '0, 1'b0, 1'b0, '0, 1'b0, '0, 3'b111);
    rd(3'd0, v); chk("R2 misc status bits", v, 32'h0B00);
    wr(3'd0, 32'h0000_0B00);
    rd(3'd0, v); chk("R3 misc cleared", v, 32'h0000);
  endtask

  task automatic t_cmd_serr;
    logic [31:0] v;
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R7 cmd writable bits", v, 32'h0B03);
    chk("R8 serr low no status", {31'b0, serr_o}, 32'h0);
    step(1'b0, 3'd0, '0, 1'b0, 1'b0, '0, 1'b0, '0, 3'b100);
    chk("R8 serr on thermal", {31'b0, serr_o}, 32'h1);
    wr(3'd1, 32'h0000_0003);
    chk("R8 serr masked", {31'b0, serr_o}, 32'h0);
    wr(3'd0, 32'h0000_0800);
  endtask

  task automatic t_race;
    logic [31:0] v;
    ecc(1'b1, 1'b0, 33'h0_0000_0100, 1'b0, 8'h44);
    step(1'b1, 3'd0, 32'h0000_0001, 1'b1, 1'b0, 33'h0_0000_0200, 1'b0, 8'h55, 3'b000);
    rd(3'd0, v); chk("R9 event beats clear", v, 32'h0001);
    wr(3'd0, 32'h0000_0001);
    rd(3'd0, v); chk("R9 later clear", v, 32'h0000);
  endtask

  task automatic t_ro_map;
    logic [31:0] v;
    ecc(1'b1, 1'b0, 33'h0_4000_0080, 1'b1, 8'h99);
    wr(3'd2, 32'h0000_0000);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'h0000_0000);
    expect_log("R10 logged regs read-only", 32'h4000_0081, 32'h0, 32'h99);
    for (int i = 5; i < 8; i++) begin
      rd(3'(i), v); chk("R11 unused select zero", v, 32'h0);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ce_log();
    t_ue_over();
    t_w1c();
    t_both();
    t_misc();
    t_cmd_serr();
    t_race();
    t_ro_map();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule